// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block does the bookkeeping for a shared packet buffer of 256-byte pages in a small Ethernet controller. A host writes one command byte at a time. The top three bits select an operation and the low five bits carry an argument. The block hands out packet numbers together with page counts, keeps a transmit queue and a receive queue of packet numbers, and returns pages to the pool when a packet is released. The buffer RAM data path is outside the block. Only ownership, counts and queue order are kept here.

The receive side of the MAC asks for buffer space through its own request port. A granted receive packet goes straight into the receive queue. Receive requests must leave a host-programmed number of pages free for transmit use. Host allocations ignore that reservation. Releasing a packet takes one cycle per page, and `busy` is high for all of that time. The block reports the last host allocation result, both queue heads with their empty flags, and the free and total page counts. It also raises an allocation-complete flag.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, `mem_info` reads {free = 32, total = 32}. `q_status` reads 16'h8080, meaning both queues are empty and both head fields are zero. `alloc_result` reads 8'h80, and `busy` and `alloc_irq` are low.
- R2: Host command code 1 (`cmd_byte[7:5]` = 3'b001) requests `cmd_byte[4:0]`+1 pages. On success, the next cycle shows the lowest unused packet number in `alloc_result[6:0]` with bit 7 clear, and the free count drops by the page count.
- R3: A host allocation that asks for more pages than are free leaves `alloc_result` = 8'h80 and leaves the free count unchanged.
- R4: Every accepted allocate command sets `alloc_irq`, whether it succeeds or fails. `irq_ack` clears the flag. When an ack and an allocate command arrive in the same cycle, the flag stays set.
- R5: A receive request for `rx_pages_m1`+1 pages succeeds only when the page count plus `tx_reserve` does not exceed the free pages. One cycle later `rx_done` is high and `rx_ok` shows the outcome. On success, `rx_num` holds the lowest unused number, that number joins the tail of the receive queue, and the queue head and empty flag appear in `q_status[15:8]` (bit 15 = empty).
- R6: A receive request in a cycle where a host command other than code 0 is accepted is refused: `rx_done` = 1, `rx_ok` = 0, and no state changes on its behalf.
- R7: Code 3 drops the receive queue head without returning its pages.
- R8: Code 4 drops the receive queue head and releases it. `busy` then stays high for exactly as many cycles as the packet has pages. The free count rises in the cycle that `busy` falls, and from then on the packet number can be reused.
- R9: Any command written while `busy` is high has no effect.
- R10: Code 5 releases the packet named by `pnr`, with the same busy timing as R8. If `pnr` names an unused packet, the command is ignored.
- R11: Code 6 appends packet `pnr` to the transmit queue, which is first in, first out. Its head shows in `q_status[6:0]` and its empty flag in bit 7. Code 7 empties the transmit queue without freeing any pages.
- R12: Code 2 returns the block to its R1 state. Code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | [7:5] operation code, [4:0] page count minus one |
| pnr | input | 5 | Packet number used by codes 5 and 6 |
| tx_reserve | input | 5 | Pages kept back from receive requests |
| irq_ack | input | 1 | Clears the allocation-complete flag |
| rx_req | input | 1 | Receive-side buffer request |
| rx_pages_m1 | input | 5 | Receive request page count minus one |
| busy | output | 1 | Release in progress |
| alloc_irq | output | 1 | Allocation-complete flag |
| alloc_result | output | 8 | [7] failed, [6:0] packet number |
| q_status | output | 16 | [15] RX empty, [14:8] RX head, [7] TX empty, [6:0] TX head |
| mem_info | output | 16 | [15:8] free pages, [7:0] total pages |
| rx_done | output | 1 | Receive request answered |
| rx_ok | output | 1 | Receive request granted |
| rx_num | output | 5 | Packet number granted to the receive side |

## Verification
Two collisions between functions are tested directly. The first is a receive request raised in the same cycle as a host enqueue command. The bench expects the enqueue to take effect and the receive side to get `rx_done` with `rx_ok` low. The second is an acknowledge of the interrupt flag in the same cycle as an allocate command, where the flag must stay set. A third case writes an allocate command in the middle of a 26-cycle release: the result byte must not change and the busy window must still last exactly 26 cycles.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int PAGES = 32,
  parameter int PKTS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic [4:0] pnr,
  input  logic [4:0] tx_reserve,
  input  logic       irq_ack,
  input  logic       rx_req,
  input  logic [4:0] rx_pages_m1,
  output logic       busy,
  output logic       alloc_irq,
  output logic [7:0] alloc_result,
  output logic [15:0] q_status,
  output logic [15:0] mem_info,
  output logic       rx_done,
  output logic       rx_ok,
  output logic [4:0] rx_num
);
  localparam int PW = $clog2(PKTS);
  localparam int CW = $clog2(PAGES + 1);
  localparam logic [2:0] OP_NOP = 3'd0, OP_ALLOC = 3'd1, OP_CLEAR = 3'd2, OP_DROP = 3'd3,
                         OP_POPREL = 3'd4, OP_REL = 3'd5, OP_TXPUSH = 3'd6, OP_TXCLR = 3'd7;

  logic [PKTS-1:0] used;
  logic [CW-1:0]   pkt_pg [PKTS];
  logic [PW-1:0]   txq [PKTS];
  logic [PW-1:0]   rxq [PKTS];
  logic [PW-1:0]   tx_rd, tx_wr, rx_rd, rx_wr, rel_pkt;
  logic [PW:0]     tx_cnt, rx_cnt;
  logic [CW-1:0]   free_cnt, rel_cnt;

  logic [2:0]    op;
  logic          acc, found, h_take, r_take, rel_start, rel_end, rx_pop, tx_push;
  logic [PW-1:0] lo, rel_sel, pnr_i;
  logic [CW-1:0] need_h, need_r, take, give;

  assign op     = cmd_byte[7:5];
  assign acc    = cmd_wr && !busy;
  assign busy   = rel_cnt != '0;
  assign pnr_i  = PW'(pnr);
  assign need_h = CW'(cmd_byte[4:0]) + CW'(1);
  assign need_r = CW'(rx_pages_m1) + CW'(1);

  always_comb begin
    found = 1'b0;
    lo    = '0;
    for (int i = PKTS - 1; i >= 0; i--)
      if (!used[i]) begin
        found = 1'b1;
        lo    = PW'(i);
      end
  end

  assign h_take    = acc && op == OP_ALLOC && found && need_h <= free_cnt;
  assign r_take    = rx_req && !(acc && op != OP_NOP) && found &&
                     ({1'b0, need_r} + (CW+1)'(tx_reserve) <= {1'b0, free_cnt});
  assign rx_pop    = acc && (op == OP_DROP || op == OP_POPREL) && rx_cnt != '0;
  assign rel_sel   = (op == OP_POPREL) ? rxq[rx_rd] : pnr_i;
  assign rel_start = acc && ((op == OP_POPREL && rx_cnt != '0) || (op == OP_REL && used[pnr_i]));
  assign rel_end   = rel_cnt == CW'(1);
  assign tx_push   = acc && op == OP_TXPUSH && used[pnr_i] && tx_cnt != (PW+1)'(PKTS);
  assign take      = h_take ? need_h : (r_take ? need_r : '0);
  assign give      = rel_end ? pkt_pg[rel_pkt] : '0;

  assign mem_info = {8'(free_cnt), 8'(PAGES)};
  assign q_status = {rx_cnt == '0, (rx_cnt == '0) ? 7'd0 : 7'(rxq[rx_rd]),
                     tx_cnt == '0, (tx_cnt == '0) ? 7'd0 : 7'(txq[tx_rd])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0; free_cnt <= CW'(PAGES); rel_cnt <= '0; rel_pkt <= '0;
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
      alloc_result <= 8'h80; alloc_irq <= 1'b0;
      rx_done <= 1'b0; rx_ok <= 1'b0; rx_num <= '0;
    end else begin
      rx_done <= rx_req;
      rx_ok   <= r_take;
      if (acc && op == OP_CLEAR) begin
        used <= '0; free_cnt <= CW'(PAGES); rel_cnt <= '0;
        tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
        rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
        alloc_result <= 8'h80; alloc_irq <= 1'b0;
      end else begin
        free_cnt <= free_cnt - take + give;
        if (acc && op == OP_ALLOC) begin
          alloc_irq    <= 1'b1;
          alloc_result <= h_take ? {1'b0, 7'(lo)} : 8'h80;
        end else if (irq_ack) alloc_irq <= 1'b0;
        if (h_take || r_take) begin
          used[lo]   <= 1'b1;
          pkt_pg[lo] <= take;
        end
        if (r_take) begin
          rxq[rx_wr] <= lo;
          rx_wr      <= rx_wr + 1'b1;
          rx_num     <= 5'(lo);
        end
        if (rx_pop) rx_rd <= rx_rd + 1'b1;
        rx_cnt <= rx_cnt + (PW+1)'(r_take) - (PW+1)'(rx_pop);
        if (acc && op == OP_TXCLR) begin
          tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
        end else if (tx_push) begin
          txq[tx_wr] <= pnr_i;
          tx_wr      <= tx_wr + 1'b1;
          tx_cnt     <= tx_cnt + 1'b1;
        end
        if (rel_start) begin
          rel_cnt <= pkt_pg[rel_sel];
          rel_pkt <= rel_sel;
        end else if (busy) begin
          rel_cnt <= rel_cnt - 1'b1;
          if (rel_end) used[rel_pkt] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
  parameter int PAGES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] cmd_byte,
  input logic       rx_req,
  input logic       busy,
  input logic       alloc_irq,
  input logic [7:0] alloc_result,
  input logic [15:0] q_status,
  input logic [15:0] mem_info,
  input logic       rx_done,
  input logic       rx_ok
);
  always_comb
    if (rst_n) assert_free_le_total_R8: assert (mem_info[15:8] <= mem_info[7:0]);

  assert_irq_on_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && cmd_byte[7:5] == 3'd1 |=> alloc_irq);

  assert_alloc_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && cmd_byte[7:5] == 3'd1 && ({4'd0, cmd_byte[4:0]} + 9'd1 > {1'b0, mem_info[15:8]})
    |=> alloc_result[7]);

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !rx_req |=> $stable(alloc_result) && $stable(q_status));

  assert_clear_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && cmd_byte[7:5] == 3'd2
    |=> mem_info[15:8] == 8'(PAGES) && q_status[15] && q_status[7] && !busy);

  assert_rx_queued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_ok |-> !q_status[15]);
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .rx_req(rx_req),
  .busy(busy), .alloc_irq(alloc_irq), .alloc_result(alloc_result), .q_status(q_status),
  .mem_info(mem_info), .rx_done(rx_done), .rx_ok(rx_ok)
);

// File: tb/tb_pkt_page_alloc.sv
module tb_pkt_page_alloc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, irq_ack = 1'b0, rx_req = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [4:0] pnr = '0, tx_reserve = '0, rx_pages_m1 = '0;
  logic busy, alloc_irq, rx_done, rx_ok;
  logic [7:0] alloc_result;
  logic [15:0] q_status, mem_info;
  logic [4:0] rx_num;
  int checks = 0, fails = 0;

  pkt_page_alloc dut (.*);

  always #2 clk = ~clk;

  // {cmd_byte, pnr, expected alloc_result, expected free pages}
  localparam logic [28:0] VEC [7] = '{
    {8'h22, 5'd0, 8'h00, 8'd29},
    {8'h20, 5'd0, 8'h01, 8'd28},
    {8'h3B, 5'd0, 8'h02, 8'd0},
    {8'h20, 5'd0, 8'h80, 8'd0},
    {8'hA0, 5'd1, 8'h80, 8'd1},
    {8'h20, 5'd0, 8'h01, 8'd0},
    {8'h00, 5'd0, 8'h01, 8'd0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(logic [7:0] b, logic [4:0] p);
    cmd_wr = 1'b1; cmd_byte = b; pnr = p;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_rx(logic [4:0] m1);
    rx_req = 1'b1; rx_pages_m1 = m1;
    @(negedge clk);
    rx_req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mem_info", mem_info, 16'h2020);
    check("R1 q_status", q_status, 16'h8080);
    check("R1 result/busy/irq", {alloc_result, 6'd0, busy, alloc_irq}, 16'h8000);

    foreach (VEC[i]) begin
      do_cmd(VEC[i][28:21], VEC[i][20:16]);
      wait_idle(n);
      check("R2/R3/R10/R12 table result", {8'd0, alloc_result}, {8'd0, VEC[i][15:8]});
      check("R2/R3/R10/R12 table free", {8'd0, mem_info[15:8]}, {8'd0, VEC[i][7:0]});
    end

    check("R4 irq set", {15'd0, alloc_irq}, 16'd1);
    irq_ack = 1'b1;
    do_cmd(8'h20, 5'd0);
    irq_ack = 1'b0;
    check("R4 set wins over ack", {15'd0, alloc_irq}, 16'd1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R4 ack clears", {15'd0, alloc_irq}, 16'd0);

    do_cmd(8'h40, 5'd0);
    check("R12 clear free", mem_info, 16'h2020);
    check("R12 clear queues", q_status, 16'h8080);
    check("R12 clear result", {8'd0, alloc_result}, 16'h0080);

    tx_reserve = 5'd4;
    do_rx(5'd1);
    check("R5 rx grant", {rx_done, rx_ok, 9'd0, rx_num}, {2'b11, 14'd0});
    check("R5 rx head", {8'd0, q_status[15:8]}, 16'h0000);
    check("R5 free", {8'd0, mem_info[15:8]}, 16'd30);
    do_rx(5'd26);
    check("R5 reservation refuses", {14'd0, rx_done, rx_ok}, 16'b10);
    do_rx(5'd25);
    check("R5 rx grant at limit", {rx_done, rx_ok, 9'd0, rx_num}, {2'b11, 9'd0, 5'd1});
    check("R5 free at reserve", {8'd0, mem_info[15:8]}, 16'd4);

    do_cmd(8'h24, 5'd0);
    check("R3 host fail", {8'd0, alloc_result, mem_info[15:8]}, {8'd0, 8'h80, 8'd4});
    do_cmd(8'h23, 5'd0);
    check("R2 host ignores reserve", {alloc_result, mem_info[15:8]}, {8'h02, 8'd0});

    rx_req = 1'b1; rx_pages_m1 = 5'd0;
    do_cmd(8'hC0, 5'd2);
    rx_req = 1'b0;
    check("R6 rx refused on collision", {14'd0, rx_done, rx_ok}, 16'b10);
    check("R11 tx head", {8'd0, q_status[7:0]}, 16'h0002);
    check("R6 rx queue untouched", {8'd0, q_status[15:8]}, 16'h0000);
    do_cmd(8'hC0, 5'd0);
    check("R11 fifo order", {8'd0, q_status[7:0]}, 16'h0002);
    do_cmd(8'hE0, 5'd0);
    check("R11 tx cleared, pages kept", {q_status[7:0], mem_info[15:8]}, {8'h80, 8'd0});

    do_cmd(8'h60, 5'd0);
    check("R7 drop pops head", {q_status[15:8], mem_info[15:8]}, {8'h01, 8'd0});

    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    do_cmd(8'h80, 5'd0);
    n = 1;
    check("R8 busy rises", {15'd0, busy}, 16'd1);
    do_cmd(8'h20, 5'd0);
    check("R9 cmd ignored while busy", {7'd0, alloc_irq, alloc_result}, 16'h0002);
    begin
      int m;
      wait_idle(m);
      n += m;
    end
    check("R8 busy length", 16'(n), 16'd26);
    check("R8 pages returned", {q_status[15:8], mem_info[15:8]}, {8'h80, 8'd26});

    do_cmd(8'hA0, 5'd5);
    check("R10 unused pnr ignored", {7'd0, busy, mem_info[15:8]}, {8'd0, 8'd26});
    do_cmd(8'hA0, 5'd2);
    n = 0;
    wait_idle(n);
    check("R10 busy length", 16'(n), 16'd4);
    check("R10 pages returned", {8'd0, mem_info[15:8]}, 16'd30);
    do_cmd(8'h20, 5'd0);
    check("R8 number reused", {alloc_result, mem_info[15:8]}, {8'h01, 8'd29});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule